// File: doc/BRIEF.md
# 8-bit ALU with Condition Codes

This block is the combinational arithmetic and logic unit of an 8-bit accumulator machine. Each call takes two operands and an operation code, and the block returns a result. For each of six condition flags it returns a next value and an enable. The six flags are carry, overflow, zero, sign, half carry and interrupt mask. The incoming carry for add-with-carry, subtract-with-carry and the rotates is the carry bit of the current flag word.

Every operation has its own flag policy. A flag can be recomputed from the result, forced to a fixed value, or left alone. A flag that is left alone has its enable low, and its next value equals the incoming value. Compare, bit test and test work only on the flags, so they drop the result write enable. Operand fetch, register storage and decimal adjust are the job of the surrounding datapath.

Unary operations act on operand A. The transfer operation passes operand B through.

Top module: `alu8_cc`

## Requirements
- R1: Flag word bit positions are: carry bit 0, overflow bit 1, zero bit 2, sign bit 3, half carry bit 4, interrupt mask bit 5. For add (A+B) and add-with-carry (A+B+carry_in), the carry flag is the carry out of bit 7. Half carry is the carry from bit 3 into bit 4. Overflow is set when A and B have the same sign and the result sign differs. Zero and sign follow the result. All five flags are written.
- R2: Subtract (A-B), subtract-with-carry (A-B-carry_in) and compare (A-B) write carry, overflow, zero and sign. Carry is the borrow. Overflow is set when A and B have different signs and the result sign differs from A. Half carry is not written.
- R3: The result write enable is low for compare, bit test and test, and high for every other operation.
- R4: AND, OR, exclusive OR, bit test (A AND B) and transfer (result = B) write zero and sign from the result and force overflow to 0. Carry is not written.
- R5: Complement gives 0xFF minus A, forces carry to 1 and overflow to 0, and writes zero and sign.
- R6: Clear gives 0x00 and writes carry 0, zero 1, sign 0 and overflow 0, whatever the incoming flags.
- R7: Negate gives 0 minus A. Carry is set when A is nonzero. Overflow is set only for A = 0x80. Zero and sign are written.
- R8: Increment and decrement write zero, sign and overflow and never carry. Overflow is set only when 0x7F becomes 0x80 (increment) or 0x80 becomes 0x7F (decrement).
- R9: Test leaves A as the result, writes zero and sign from A, and forces carry and overflow to 0.
- R10: Arithmetic shift left moves bit 7 to carry and shifts in 0. Arithmetic shift right keeps bit 7 and moves bit 0 to carry. Logical shift right shifts in 0 at bit 7 and moves bit 0 to carry.
- R11: Rotate left moves carry_in into bit 0 and bit 7 into carry. Rotate right moves carry_in into bit 7 and bit 0 into carry.
- R12: For every shift and rotate, the new overflow equals the new sign XOR the new carry, and zero and sign follow the result.
- R13: The interrupt mask is never written. Any flag whose enable is low has a next value equal to its incoming value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 5 | Operation select (package enumeration) |
| opnd_a | input | 8 | First operand; the operand of unary operations |
| opnd_b | input | 8 | Second operand |
| flags_in | input | 6 | Current flag word; bit 0 is the incoming carry |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_nxt | output | 6 | Next flag values |
| flags_we | output | 6 | Per-flag update enable |

## Verification
The corners that are hardest to reach from the ports are the single-value overflow cases: increment of 0x7F, decrement of 0x80 and negate of 0x80. The half-carry boundary of an add is another. Random operands hit these only about once in 256 draws per operation. The stimulus therefore adds directed vectors for each of them, and for add and subtract with and without an incoming carry at the 0x7F/0x80 and 0xFF/0x00 edges. Random flag words, including a set interrupt mask, show that unwritten flags pass through for every operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
    OP_AND, OP_BIT, OP_OR,  OP_XOR, OP_PASS,
    OP_COM, OP_NEG, OP_CLR, OP_TST, OP_INC,
    OP_DEC, OP_ASL, OP_ASR, OP_LSR, OP_ROL,
    OP_ROR
  } alu_op_e;

  localparam int OP_COUNT = 21;

  localparam int FLAG_N = 6;
  localparam int FC = 0;
  localparam int FO = 1;
  localparam int FZ = 2;
  localparam int FS = 3;
  localparam int FH = 4;
  localparam int FI = 5;

  typedef enum logic [1:0] { SRC_ADDER, SRC_LOGIC, SRC_SHIFT } res_src_e;

  function automatic logic uses_adder(alu_op_e o);
    return o inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG, OP_INC, OP_DEC};
  endfunction

  function automatic logic is_shift(alu_op_e o);
    return o inside {OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR};
  endfunction

  function automatic logic is_logic(alu_op_e o);
    return o inside {OP_AND, OP_BIT, OP_OR, OP_XOR, OP_PASS};
  endfunction

  function automatic logic flags_only(alu_op_e o);
    return o inside {OP_CMP, OP_BIT, OP_TST};
  endfunction

  function automatic res_src_e pick_src(alu_op_e o);
    if (uses_adder(o)) return SRC_ADDER;
    if (is_shift(o))   return SRC_SHIFT;
    return SRC_LOGIC;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_flag,
  output logic         half_carry,
  output logic         overflow
);
  localparam int HB = W / 2;

  logic [W-1:0]  y_eff;
  logic          c0;
  logic [W:0]    full;
  logic [HB:0]   low;

  always_comb begin
    y_eff = sub ? ~y : y;
    c0    = sub ? ~cin : cin;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c0};
    low   = {1'b0, x[HB-1:0]} + {1'b0, y_eff[HB-1:0]} + {{HB{1'b0}}, c0};
    sum        = full[W-1:0];
    carry_flag = sub ? ~full[W] : full[W];
    half_carry = low[HB];
    overflow   = (x[W-1] == y_eff[W-1]) && (full[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND, OP_BIT: y = a & b;
      OP_OR:          y = a | b;
      OP_XOR:         y = a ^ b;
      OP_PASS:        y = b;
      OP_COM:         y = ~a;
      OP_CLR:         y = '0;
      default:        y = a;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);
  always_comb begin
    unique case (op)
      OP_ASL:  begin y = {a[W-2:0], 1'b0};    cout = a[W-1]; end
      OP_ASR:  begin y = {a[W-1], a[W-1:1]};  cout = a[0];   end
      OP_LSR:  begin y = {1'b0, a[W-1:1]};    cout = a[0];   end
      OP_ROL:  begin y = {a[W-2:0], cin};     cout = a[W-1]; end
      OP_ROR:  begin y = {cin, a[W-1:1]};     cout = a[0];   end
      default: begin y = a;                   cout = cin;    end
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e             op,
  input  logic [W-1:0]        res,
  input  logic                add_c,
  input  logic                add_h,
  input  logic                add_o,
  input  logic                sh_c,
  input  logic [FLAG_N-1:0]   flags_in,
  output logic [FLAG_N-1:0]   flags_nxt,
  output logic [FLAG_N-1:0]   flags_we,
  output logic                res_we
);
  logic res_zero, res_sign;
  logic [FLAG_N-1:0] val;

  always_comb begin
    res_zero = (res == '0);
    res_sign = res[W-1];
    val      = '0;
    flags_we = '0;
    val[FZ]  = res_zero;
    val[FS]  = res_sign;
    unique case (op)
      OP_ADD, OP_ADC: begin
        flags_we[FC] = 1'b1; flags_we[FO] = 1'b1; flags_we[FZ] = 1'b1;
        flags_we[FS] = 1'b1; flags_we[FH] = 1'b1;
        val[FC] = add_c; val[FO] = add_o; val[FH] = add_h;
      end
      OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        flags_we[FC] = 1'b1; flags_we[FO] = 1'b1;
        flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FC] = add_c; val[FO] = add_o;
      end
      OP_INC, OP_DEC: begin
        flags_we[FO] = 1'b1; flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FO] = add_o;
      end
      OP_AND, OP_BIT, OP_OR, OP_XOR, OP_PASS: begin
        flags_we[FO] = 1'b1; flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FO] = 1'b0;
      end
      OP_COM: begin
        flags_we[FC] = 1'b1; flags_we[FO] = 1'b1;
        flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FC] = 1'b1; val[FO] = 1'b0;
      end
      OP_CLR, OP_TST: begin
        flags_we[FC] = 1'b1; flags_we[FO] = 1'b1;
        flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FC] = 1'b0; val[FO] = 1'b0;
      end
      default: begin
        flags_we[FC] = 1'b1; flags_we[FO] = 1'b1;
        flags_we[FZ] = 1'b1; flags_we[FS] = 1'b1;
        val[FC] = sh_c; val[FO] = res_sign ^ sh_c;
      end
    endcase
    flags_nxt = (val & flags_we) | (flags_in & ~flags_we);
    res_we    = !flags_only(op);
  end
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]        op,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [FLAG_N-1:0] flags_in,
  output logic [W-1:0]      result,
  output logic              result_we,
  output logic [FLAG_N-1:0] flags_nxt,
  output logic [FLAG_N-1:0] flags_we
);
  localparam logic [W-1:0] ONE = W'(1);

  alu_op_e  op_e;
  res_src_e src;
  logic     carry_in;

  // operand routing into the shared adder
  logic [W-1:0] add_x, add_y;
  logic         add_sub, add_cin;

  // internal events brought out for the checker
  logic [W-1:0] add_sum, logic_res, shift_res;
  logic         add_carry, half_carry, add_ovf, shift_carry;

  always_comb begin
    op_e     = alu_op_e'(op);
    src      = pick_src(op_e);
    carry_in = flags_in[FC];
    add_x    = opnd_a;
    add_y    = opnd_b;
    add_sub  = 1'b0;
    add_cin  = 1'b0;
    unique case (op_e)
      OP_ADC:         add_cin = carry_in;
      OP_SUB, OP_CMP: add_sub = 1'b1;
      OP_SBC:         begin add_sub = 1'b1; add_cin = carry_in; end
      OP_NEG:         begin add_sub = 1'b1; add_x = '0; add_y = opnd_a; end
      OP_INC:         add_y = ONE;
      OP_DEC:         begin add_sub = 1'b1; add_y = ONE; end
      default:        ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(add_x), .y(add_y), .sub(add_sub), .cin(add_cin),
    .sum(add_sum), .carry_flag(add_carry),
    .half_carry(half_carry), .overflow(add_ovf)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(logic_res)
  );

  alu8_shift #(.W(W)) u_shift (
    .op(op_e), .a(opnd_a), .cin(carry_in), .y(shift_res), .cout(shift_carry)
  );

  always_comb begin
    unique case (src)
      SRC_ADDER: result = add_sum;
      SRC_SHIFT: result = shift_res;
      default:   result = logic_res;
    endcase
  end

  alu8_flags #(.W(W)) u_flags (
    .op(op_e), .res(result),
    .add_c(add_carry), .add_h(half_carry), .add_o(add_ovf), .sh_c(shift_carry),
    .flags_in(flags_in), .flags_nxt(flags_nxt), .flags_we(flags_we),
    .res_we(result_we)
  );
endmodule

// File: rtl/alu8_cc_chk.sv
module alu8_cc_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]        op,
  input logic [W-1:0]      opnd_a,
  input logic [W-1:0]      opnd_b,
  input logic [FLAG_N-1:0] flags_in,
  input logic [W-1:0]      result,
  input logic              result_we,
  input logic [FLAG_N-1:0] flags_nxt,
  input logic [FLAG_N-1:0] flags_we,
  input logic              add_carry,
  input logic              shift_carry
);
  alu_op_e o;
  logic [W:0] plain_sum;

  always_comb begin
    o = alu_op_e'(op);
    plain_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
    if (o == OP_ADD) begin
      // R1
      add_sum_chk: assert ({add_carry, result} == plain_sum);
    end
    if (flags_we[FH]) begin
      // R2
      half_only_add_chk: assert (o == OP_ADD || o == OP_ADC);
    end
    // R3
    result_we_chk: assert (result_we == !(o == OP_CMP || o == OP_BIT || o == OP_TST));
    if (is_logic(o)) begin
      // R4
      logic_ovf_chk: assert (flags_we[FO] && !flags_nxt[FO] && !flags_we[FC]);
    end
    if (o == OP_CLR) begin
      // R6
      clear_chk: assert (result == '0 && flags_nxt[FC] == 1'b0 && flags_nxt[FZ] == 1'b1 &&
                         flags_nxt[FS] == 1'b0 && flags_nxt[FO] == 1'b0);
    end
    if (o == OP_INC || o == OP_DEC) begin
      // R8
      incdec_carry_chk: assert (!flags_we[FC] && flags_nxt[FC] == flags_in[FC]);
    end
    if (is_shift(o)) begin
      // R12
      shift_ovf_chk: assert (flags_nxt[FO] == (result[W-1] ^ shift_carry) &&
                             flags_nxt[FC] == shift_carry);
    end
    if (flags_we[FZ]) begin
      // R12
      zero_flag_chk: assert (flags_nxt[FZ] == (result == '0));
    end
    // R13
    imask_chk: assert (!flags_we[FI] && flags_nxt[FI] == flags_in[FI]);
    // R13
    pass_through_chk: assert (((flags_nxt ^ flags_in) & ~flags_we) == '0);
  end
endmodule

bind alu8_cc alu8_cc_chk #(.W(W)) u_chk (
  .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
  .result(result), .result_we(result_we), .flags_nxt(flags_nxt),
  .flags_we(flags_we), .add_carry(add_carry), .shift_carry(shift_carry)
);

// File: tb/tb_alu8_cc.sv
module tb_alu8_cc;
  import alu8_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] op;
  logic [7:0] opnd_a, opnd_b, result;
  logic [5:0] flags_in, flags_nxt, flags_we;
  logic       result_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  alu8_cc dut (
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_in(flags_in),
    .result(result), .result_we(result_we), .flags_nxt(flags_nxt),
    .flags_we(flags_we)
  );

  function automatic string tag_of(alu_op_e o);
    case (o)
      OP_ADD, OP_ADC:                  return "R1";
      OP_SUB, OP_SBC, OP_CMP:          return "R2";
      OP_AND, OP_BIT, OP_OR, OP_XOR, OP_PASS: return "R4";
      OP_COM:                          return "R5";
      OP_CLR:                          return "R6";
      OP_NEG:                          return "R7";
      OP_INC, OP_DEC:                  return "R8";
      OP_TST:                          return "R9";
      OP_ASL, OP_ASR, OP_LSR:          return "R10";
      default:                         return "R11";
    endcase
  endfunction

  // Expected {result, result_we, we[5:0], nxt[5:0]}
  function automatic logic [20:0] model(alu_op_e o, int a, int b, logic [5:0] f);
    int r = a, c = f[0], v = 0, h = 0, diff, tot;
    logic [5:0] we = 6'b0;
    logic rw = 1'b1;
    logic [5:0] nx;
    bit sh = 0;
    case (o)
      OP_ADD, OP_ADC: begin
        tot = a + b + ((o == OP_ADC) ? c : 0);
        h = (((a % 16) + (b % 16) + ((o == OP_ADC) ? c : 0)) >= 16) ? 1 : 0;
        r = tot % 256; c = (tot >= 256) ? 1 : 0;
        v = ((a >= 128) == (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
        we = 6'b011111;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        diff = a - b - ((o == OP_SBC) ? c : 0);
        c = (diff < 0) ? 1 : 0; r = (diff + 256) % 256;
        v = ((a >= 128) != (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0;
        we = 6'b001111; rw = (o != OP_CMP);
      end
      OP_NEG: begin r = (256 - a) % 256; c = (a != 0); v = (a == 128); we = 6'b001111; end
      OP_INC: begin r = (a + 1) % 256; v = (a == 127); we = 6'b001110; end
      OP_DEC: begin r = (a + 255) % 256; v = (a == 128); we = 6'b001110; end
      OP_AND, OP_BIT: begin r = a & b; we = 6'b001110; rw = (o == OP_AND); end
      OP_OR:   begin r = a | b; we = 6'b001110; end
      OP_XOR:  begin r = a ^ b; we = 6'b001110; end
      OP_PASS: begin r = b;     we = 6'b001110; end
      OP_COM:  begin r = 255 - a; c = 1; we = 6'b001111; end
      OP_CLR:  begin r = 0; c = 0; we = 6'b001111; end
      OP_TST:  begin r = a; c = 0; we = 6'b001111; rw = 1'b0; end
      OP_ASL:  begin c = a / 128; r = (a * 2) % 256; sh = 1; end
      OP_ASR:  begin c = a % 2; r = (a / 2) + (a & 128); sh = 1; end
      OP_LSR:  begin c = a % 2; r = a / 2; sh = 1; end
      OP_ROL:  begin r = ((a * 2) % 256) + f[0]; c = a / 128; sh = 1; end
      default: begin r = (a / 2) + 128 * f[0]; c = a % 2; sh = 1; end
    endcase
    if (sh) begin we = 6'b001111; v = ((r >= 128) != (c == 1)) ? 1 : 0; end
    nx = f;
    if (we[0]) nx[0] = c[0];
    if (we[1]) nx[1] = v[0];
    if (we[2]) nx[2] = (r == 0);
    if (we[3]) nx[3] = (r >= 128);
    if (we[4]) nx[4] = h[0];
    return {r[7:0], rw, we, nx};
  endfunction

  task automatic run(input alu_op_e o, input logic [7:0] a, input logic [7:0] b,
                     input logic [5:0] f, input string note);
    logic [20:0] exp_v, act;
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; flags_in = f;
    #1;
    exp_v = model(o, int'(a), int'(b), f);
    act   = {result, result_we, flags_we, flags_nxt};
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s op=%s a=%h b=%h f=%b: got res=%h we=%b fwe=%b fn=%b expected res=%h we=%b fwe=%b fn=%b",
               tag_of(o), note, o.name(), a, b, f,
               act[20:13], act[12], act[11:6], act[5:0],
               exp_v[20:13], exp_v[12], exp_v[11:6], exp_v[5:0]);
    end
  endtask

  initial begin
    op = 5'(OP_CLR); opnd_a = '0; opnd_b = '0; flags_in = '0;
    void'($urandom(32'h5eed_0a1c));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R6 initial state: clear with all flags set
    run(OP_CLR, 8'h00, 8'h00, 6'b111111, "clear after reset");
    // R1 add corners: half carry and signed overflow, carry out to zero
    run(OP_ADD, 8'h7F, 8'h01, 6'b000000, "7F+01");
    run(OP_ADD, 8'hFF, 8'h01, 6'b000000, "FF+01");
    run(OP_ADC, 8'h7F, 8'h00, 6'b000001, "adc 7F+0+1");
    run(OP_ADC, 8'h80, 8'h80, 6'b000001, "adc 80+80+1");
    // R2 subtract corners
    run(OP_SUB, 8'h00, 8'h01, 6'b010000, "00-01");
    run(OP_SBC, 8'h80, 8'h00, 6'b000001, "sbc 80-0-1");
    run(OP_CMP, 8'h42, 8'h42, 6'b000000, "equal compare");
    // R3 R9 flags-only operations
    run(OP_BIT, 8'hF0, 8'h0F, 6'b100001, "bit test zero");
    run(OP_TST, 8'h80, 8'h00, 6'b000011, "test negative");
    // R5 complement
    run(OP_COM, 8'h00, 8'h00, 6'b000010, "complement zero");
    // R7 negate corners
    run(OP_NEG, 8'h80, 8'h00, 6'b000000, "neg 80");
    run(OP_NEG, 8'h00, 8'h00, 6'b000011, "neg 00");
    // R8 increment and decrement edges
    run(OP_INC, 8'h7F, 8'h00, 6'b000001, "inc 7F");
    run(OP_INC, 8'hFF, 8'h00, 6'b000000, "inc FF keeps carry");
    run(OP_DEC, 8'h80, 8'h00, 6'b000000, "dec 80");
    run(OP_DEC, 8'h00, 8'h00, 6'b000001, "dec 00");
    // R10 R11 R12 shifts and rotates
    run(OP_ASR, 8'h81, 8'h00, 6'b000000, "asr 81");
    run(OP_LSR, 8'h01, 8'h00, 6'b000000, "lsr 01");
    run(OP_ASL, 8'h80, 8'h00, 6'b000000, "asl 80");
    run(OP_ROL, 8'h40, 8'h00, 6'b000001, "rol carry in");
    run(OP_ROR, 8'h01, 8'h00, 6'b000001, "ror carry in");
    // R4 logic with interrupt mask set (R13)
    run(OP_PASS, 8'h00, 8'h80, 6'b100011, "transfer negative");
    run(OP_XOR, 8'h5A, 8'h5A, 6'b110001, "xor to zero");
    // random mix over all operations and flag words (R13)
    for (int i = 0; i < N_RANDOM; i++) begin
      run(alu_op_e'($urandom % OP_COUNT), 8'($urandom), 8'($urandom),
          6'($urandom), "random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule